// File: doc/BRIEF.md
# Refresh Interval Timer

This block paces auto-refresh for a DDR-SDRAM command sequencer. A small write port holds a refresh-enable bit and a 3-bit interval code. While enabled, a down-counter advances once per time-base tick and, on running out, raises a refresh request. The request stays raised until the sequencer acknowledges it. The counter reloads at once on expiry, so a slow acknowledge never lengthens the spacing between refreshes. The current count is visible on an output.

The block reproduces one deliberate ordering quirk. The counter takes its reload value only when enable rises, or at an expiry. On an enable rise it uses the code already held, before the current write lands. So a single write that both sets enable and changes the code runs its first period at the old spacing. Every later period uses the new spacing. A code written while disabled, followed by a separate enabling write, applies from the first period.

The control is a three-state machine:
- `ST_OFF`: disabled. The counter is held at zero.
- `ST_RUN`: counting, with no request outstanding.
- `ST_REQ`: a request is outstanding.

Its transitions are:
- `ST_OFF`→`ST_RUN` on an enable rise.
- `ST_RUN`→`ST_REQ` on expiry.
- `ST_REQ`→`ST_RUN` on acknowledge, unless an expiry happens in the same cycle, in which case it stays in `ST_REQ`.
- `ST_RUN`/`ST_REQ`→`ST_OFF` on an enable clear, which takes priority over every other event.

Top module: `rfsh_interval_timer`

## Requirements
- R1: Interval code c, carried on `wr_sel_i`, gives a spacing of (c+1)*UNIT ticks between request rises. The default UNIT is 1024 ticks, so code 0 is 1024 ticks and code 7 is 8192 ticks. With one tick per cycle, a request rises N clock edges after the previous rise or after the enabling write edge.
- R2: While enable is 0, `count_o` is 0 and `req_o` is 0.
- R3: When one write sets enable from 0 to 1 and also changes the code, the first period uses the code held before that write.
- R4: In that same-write case, the second and all later periods use the newly written code.
- R5: A code written while disabled, followed by a separate write that sets enable, applies from the very first period.
- R6: `req_o` stays 1 until `ack_i` is sampled 1 on a clock edge, and then falls on that edge.
- R7: At expiry the counter reloads on the same edge, so the next period is not stretched by a late acknowledge.
- R8: A write that clears enable returns `count_o` to 0 and `req_o` to 0 on that edge, dropping an unacknowledged request.
- R9: `count_o` shows the remaining ticks and changes only on cycles with `tick_i` high. It is loaded with the full period on the enabling edge.
- R10: After synchronous active-high reset, enable is 0, the code is 0, `count_o` is 0 and `req_o` is 0.
- R11: A write with enable 1 while already enabled does not restart the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | Register write strobe |
| wr_enable_i | input | 1 | Refresh-enable bit of the write |
| wr_sel_i | input | SEL_W | Interval code of the write |
| tick_i | input | 1 | Time-base tick (clock enable for counting) |
| ack_i | input | 1 | Acknowledge from the sequencer |
| req_o | output | 1 | Refresh request |
| count_o | output | CNT_W | Ticks remaining in the current period |

## Verification
The assertions assume that reset is applied before use and that a write is a single-cycle strobe. They make no assumption about the tick pattern or about when acknowledges arrive. The stimulus raises `ack_i` only after it has seen `req_o` high, and holds it back on purpose to test pending requests. It spaces writes so that each enabling write is observed on its own. Tick is held high except in one window that tests tick gating, so that measured request spacings equal the period in ticks.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_RUN = 2'd1,
        ST_REQ = 2'd2
    } rfsh_state_e;

    // Period length in ticks for an interval code.
    function automatic int unsigned period_ticks(input int unsigned code,
                                                 input int unsigned unit);
        return (code + 1) * unit;
    endfunction

endpackage

// File: rtl/rfsh_cfg_regs.sv
module rfsh_cfg_regs #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid_i,
    input  logic             wr_enable_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic             expire_i,
    output logic             en_q,
    output logic [SEL_W-1:0] sel_q,
    output logic [SEL_W-1:0] shadow_q,
    output logic             en_rise,
    output logic             en_fall
);

    // Edge decode uses the held enable, before the write lands.
    always_comb begin
        en_rise = wr_valid_i &&  wr_enable_i && !en_q;
        en_fall = wr_valid_i && !wr_enable_i &&  en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            sel_q <= '0;
        end else if (wr_valid_i) begin
            en_q  <= wr_enable_i;
            sel_q <= wr_sel_i;
        end
    end

    // Shadow follows the held code while disabled, and is refreshed at each
    // expiry; it records the code governing the period in progress.
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (!en_q || expire_i) begin
            shadow_q <= sel_q;
        end
    end

endmodule

// File: rtl/rfsh_down_counter.sv
module rfsh_down_counter
    import rfsh_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int UNIT  = 1024,
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_q,
    input  logic             en_rise,
    input  logic             en_fall,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire_o
);

    logic [CNT_W-1:0] load_val;

    always_comb begin
        load_val = CNT_W'(period_ticks(32'(sel_q), UNIT));
        expire_o = en_q && !en_fall && tick_i && (cnt_q == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en_fall) begin
            cnt_q <= '0;
        end else if (en_rise) begin
            cnt_q <= load_val;
        end else if (!en_q) begin
            cnt_q <= '0;
        end else if (expire_o) begin
            cnt_q <= load_val;
        end else if (tick_i && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // R9: no tick and no write means the count holds
    a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (en_q && !tick_i && !en_fall) |=> $stable(cnt_q));

    // R7: expiry reloads on the same edge with the held code
    a_r7_reload_at_expiry: assert property (@(posedge clk) disable iff (rst)
        (en_q && !en_fall && tick_i && cnt_q == CNT_W'(1))
        |=> (cnt_q == CNT_W'(period_ticks(32'($past(sel_q)), UNIT))));

endmodule

// File: rtl/rfsh_req_fsm.sv
module rfsh_req_fsm
    import rfsh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_rise,
    input  logic en_fall,
    input  logic expire_i,
    input  logic ack_i,
    output logic req_o
);

    rfsh_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (en_rise) state_d = ST_RUN;
            ST_RUN: begin
                if (en_fall)       state_d = ST_OFF;
                else if (expire_i) state_d = ST_REQ;
            end
            ST_REQ: begin
                if (en_fall)       state_d = ST_OFF;
                else if (expire_i) state_d = ST_REQ;
                else if (ack_i)    state_d = ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        req_o = (state_q == ST_REQ);
    end

    // R6: request held until acknowledged
    a_r6_req_holds: assert property (@(posedge clk) disable iff (rst)
        (req_o && !ack_i && !en_fall) |=> req_o);

    // R6: acknowledge without a new expiry drops the request
    a_r6_ack_drops: assert property (@(posedge clk) disable iff (rst)
        (req_o && ack_i && !expire_i) |=> !req_o);

endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer
    import rfsh_pkg::*;
#(
    parameter  int SEL_W = 3,
    parameter  int UNIT  = 1024,
    localparam int CNT_W = $clog2((1 << SEL_W) * UNIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid_i,
    input  logic             wr_enable_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic             tick_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic [CNT_W-1:0] count_o
);

    logic             en_q, en_rise, en_fall, expire;
    logic [SEL_W-1:0] sel_q, shadow_q;

    rfsh_cfg_regs #(.SEL_W(SEL_W)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_valid_i (wr_valid_i),
        .wr_enable_i(wr_enable_i),
        .wr_sel_i   (wr_sel_i),
        .expire_i   (expire),
        .en_q       (en_q),
        .sel_q      (sel_q),
        .shadow_q   (shadow_q),
        .en_rise    (en_rise),
        .en_fall    (en_fall)
    );

    rfsh_down_counter #(.SEL_W(SEL_W), .UNIT(UNIT), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .en_q    (en_q),
        .en_rise (en_rise),
        .en_fall (en_fall),
        .tick_i  (tick_i),
        .sel_q   (sel_q),
        .cnt_q   (count_o),
        .expire_o(expire)
    );

    rfsh_req_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en_rise (en_rise),
        .en_fall (en_fall),
        .expire_i(expire),
        .ack_i   (ack_i),
        .req_o   (req_o)
    );

    // R2: disabled means idle and quiet
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> (count_o == '0 && !req_o));

    // R3 / R5: first period loads from the code held before the enabling write
    a_r3_first_period_held: assert property (@(posedge clk) disable iff (rst)
        en_rise |=> (count_o == CNT_W'(period_ticks(32'($past(sel_q)), UNIT))));

    // R8: clearing enable clears count and request on that edge
    a_r8_disable_clears: assert property (@(posedge clk) disable iff (rst)
        en_fall |=> (count_o == '0 && !req_o));

    // R1: count never exceeds the period of the code in force
    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        en_q |-> (count_o <= CNT_W'(period_ticks(32'(shadow_q), UNIT))));

endmodule

// File: tb/sim_rfsh_interval_timer.sv
module sim_rfsh_interval_timer;

    localparam int SEL_W = 3;
    localparam int UNIT  = 32;
    localparam int CNT_W = $clog2((1 << SEL_W) * UNIT + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_valid_i = 1'b0;
    logic             wr_enable_i = 1'b0;
    logic [SEL_W-1:0] wr_sel_i = '0;
    logic             tick_i = 1'b1;
    logic             ack_i = 1'b0;
    logic             req_o;
    logic [CNT_W-1:0] count_o;

    always #2 clk = ~clk;   // 250 MHz

    rfsh_interval_timer #(.SEL_W(SEL_W), .UNIT(UNIT)) u0 (
        .clk(clk), .rst(rst), .wr_valid_i(wr_valid_i), .wr_enable_i(wr_enable_i),
        .wr_sel_i(wr_sel_i), .tick_i(tick_i), .ack_i(ack_i),
        .req_o(req_o), .count_o(count_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int mark = 0;
    int exp_q[$];
    string tag_q[$];
    bit hold_ack = 1'b0;
    bit req_prev = 1'b0;
    bit done = 1'b0;

    function automatic int per(input int code);
        return (code + 1) * UNIT;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_gap(input int gap, input string tag);
        exp_q.push_back(gap);
        tag_q.push_back(tag);
    endtask

    // Single-cycle write; returns at the negedge after the write edge.
    task automatic do_write(input bit en, input int sel, input bit set_mark);
        @(negedge clk);
        wr_valid_i  = 1'b1;
        wr_enable_i = en;
        wr_sel_i    = SEL_W'(sel);
        @(negedge clk);
        wr_valid_i = 1'b0;
        if (set_mark) mark = cyc;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: measures spacing of request rises and drives the acknowledge.
    always @(negedge clk) begin
        if (!rst) begin
            if (req_o && !req_prev) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected request", cyc - mark, -1);
                end else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check((cyc - mark) == e, t, cyc - mark, e);
                end
                mark = cyc;
            end
            req_prev = req_o;
            ack_i = req_o && !hold_ack;
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", cyc, 0);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(count_o == 0, "R10 count after reset", count_o, 0);
        check(req_o == 0, "R10 req after reset", req_o, 0);

        // R5: code written while disabled, enabled later
        do_write(1'b0, 1, 1'b0);
        repeat (4) @(negedge clk);
        check(count_o == 0 && req_o == 0, "R2 disabled idle", count_o, 0);
        expect_gap(per(1), "R5 first period new code");
        expect_gap(per(1), "R1 steady period code 1");
        do_write(1'b1, 1, 1'b1);
        check(count_o == per(1), "R9 loaded on enable", count_o, per(1));
        wait (exp_q.size() == 0);
        do_write(1'b0, 1, 1'b0);
        check(count_o == 0, "R8 count cleared", count_o, 0);

        // R3 / R4: enable and new code in one write
        expect_gap(per(1), "R3 first period held code");
        expect_gap(per(3), "R4 second period new code");
        expect_gap(per(3), "R4 third period new code");
        do_write(1'b1, 3, 1'b1);
        wait (exp_q.size() == 0);
        do_write(1'b0, 3, 1'b0);

        // R1 code 0, R11 re-enable while enabled does not restart
        do_write(1'b0, 0, 1'b0);
        expect_gap(per(0), "R1 period code 0");
        expect_gap(per(0), "R11 period not restarted");
        do_write(1'b1, 0, 1'b1);
        wait (exp_q.size() == 1);
        repeat (5) @(negedge clk);
        do_write(1'b1, 0, 1'b0);
        wait (exp_q.size() == 0);
        do_write(1'b0, 0, 1'b0);

        // R1 code 7, R6 held request, R7 no stretch
        do_write(1'b0, 7, 1'b0);
        expect_gap(per(7), "R1 period code 7");
        do_write(1'b1, 7, 1'b1);
        wait (exp_q.size() == 0);
        hold_ack = 1'b1;
        expect_gap(per(7), "R7 period code 7 again");
        wait (exp_q.size() == 0);
        repeat (6) @(negedge clk);
        check(req_o == 1, "R6 req held without ack", req_o, 1);
        check(count_o == per(7) - 6, "R7 reloaded at expiry", count_o, per(7) - 6);
        expect_gap(per(7), "R7 late ack no stretch");
        hold_ack = 1'b0;
        repeat (2) @(negedge clk);
        check(req_o == 0, "R6 req dropped after ack", req_o, 0);
        hold_ack = 1'b1;
        wait (exp_q.size() == 0);
        @(negedge clk);
        check(req_o == 1, "R6 pending before disable", req_o, 1);
        do_write(1'b0, 7, 1'b0);
        check(req_o == 0, "R8 pending request dropped", req_o, 0);
        check(count_o == 0, "R8 count zero", count_o, 0);
        hold_ack = 1'b0;

        // R9: tick gating
        do_write(1'b0, 0, 1'b0);
        do_write(1'b1, 0, 1'b1);
        repeat (3) @(negedge clk);
        check(count_o == per(0) - 3, "R9 count follows ticks", count_o, per(0) - 3);
        tick_i = 1'b0;
        repeat (10) @(negedge clk);
        check(count_o == per(0) - 3, "R9 count frozen without tick", count_o, per(0) - 3);
        tick_i = 1'b1;
        @(negedge clk);
        check(count_o == per(0) - 4, "R9 count resumes", count_o, per(0) - 4);
        do_write(1'b0, 0, 1'b0);
        repeat (per(0) + 4) @(negedge clk);
        check(req_o == 0 && count_o == 0, "R2 quiet after disable", count_o, 0);
        check(exp_q.size() == 0, "R1 all expected requests seen", exp_q.size(), 0);

        done = 1'b1;
        finish_run();
    end

endmodule